// File: doc/BRIEF.md
# TDM Timeslot Serial Data Port

This block is one side of a time-division-multiplexed serial backplane interface for a voice coding engine. It follows a bit clock and a frame sync from the backplane. It counts bit positions from each frame sync and shifts one serial word in during a programmed input timeslot. The captured word goes to a processing stub in parallel. In a programmed output timeslot of the next frame, the port shifts one word out. At all other times the serial output is left at high impedance. The backplane signals are sampled by the port's own system clock through a short synchronizer, so the bit clock must run well below the system clock.

The timeslot width follows the coding direction. When compressing, the port takes in 8-bit PCM bytes and sends out 4-bit ADPCM nibbles. When expanding, it takes in nibbles and sends out bytes. In bypass, no coding happens: the captured word is sent out unchanged one frame later. This lets a host move a word from one timeslot to another. Bypass uses bytes when the compress flag is set and nibbles when it is clear. An idle flag keeps the output off and stops capture. A busy flag, raised while the configuration is being rewritten, keeps the output off for as long as it is high.

The port contains three state machines.
- Frame timer. It has two states, `FR_HUNT` and `FR_RUN`. It takes the single transition `FR_HUNT -> FR_RUN` on the first bit-clock rising edge that finds frame sync high, and stays in `FR_RUN` after that.
- Receive path. It has two states, `RX_WAIT` and `RX_SHIFT`.
  - `RX_WAIT -> RX_SHIFT` happens on the first bit of the input slot.
  - `RX_SHIFT -> RX_WAIT` happens on any of three events: the last bit of the slot (the word is delivered), a frame sync, or a sample taken outside the slot.
- Transmit path. It has two states, `TX_HIZ` and `TX_DRIVE`.
  - `TX_HIZ -> TX_DRIVE` happens at a bit boundary inside the output slot while output is permitted.
  - `TX_DRIVE -> TX_HIZ` happens at a bit boundary outside the slot, or at once when idle, busy or loss of permission forbids output.

Top module: `tdm_slot_port`

## Requirements
- R1: Bit index 0 is the bit whose bit-clock rising edge finds frame sync high. Each later rising edge adds one to the index. The index stops at FRAME_BITS_MAX (512 by default), where no slot can match, and stays there until the next frame sync.
- R2: Serial input is sampled after bit-clock falling edges. The serial output changes only after bit-clock rising edges and holds steady for the rest of the bit.
- R3: Byte slot k covers bits 8k to 8k+7, and nibble slot k covers bits 4k to 4k+3. Each slot is selected by a 6-bit number. A slot that lies past the last bit of the frame is never captured and never driven.
- R4: With compress=1 and bypass=0, the input slot is 8 bits and the output slot is 4 bits. With compress=0 and bypass=0, the input slot is 4 bits and the output slot is 8 bits.
- R5: Every slot carries its word most significant bit first.
- R6: When an input slot is complete, rx_word_o holds the word right-justified (a nibble sits in bits 3:0 with bits 7:4 zero), and rx_valid_o is high for exactly one system-clock cycle.
- R7: In coding mode, the word driven in the output slot of a frame is the low output-width bits of tx_word_i, sampled at that frame's sync. The stub therefore answers a word captured in frame N during frame N+1.
- R8: With bypass=1, both slots are 8 bits if compress=1 and 4 bits if compress=0. The word captured in frame N is driven unchanged in frame N+1, and tx_word_i has no effect.
- R9: While cfg_idle_i is high, sdout_oe_o stays low and rx_valid_o never pulses.
- R10: While cfg_busy_i is high, sdout_oe_o stays low. Driving resumes at the next bit of the output slot after busy falls.
- R11: After reset, sdout_oe_o and rx_valid_o are low. Nothing is driven until the first frame sync is seen.
- R12: sdout_oe_o is high only during the bits of the output slot. Whenever it is low, sdout_o is high impedance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, well above the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Backplane bit clock |
| fsync_i | input | 1 | Frame sync, high for at most one bit period |
| sdin_i | input | 1 | Serial data in |
| sdout_o | output | 1 | Serial data out, high impedance when not driven |
| sdout_oe_o | output | 1 | High while sdout_o is driven |
| cfg_compress_i | input | 1 | 1 = compress (byte in), 0 = expand (nibble in) |
| cfg_bypass_i | input | 1 | 1 = copy input word to the output slot without coding |
| cfg_idle_i | input | 1 | 1 = channel idle: no output, no capture |
| cfg_busy_i | input | 1 | 1 = configuration update in progress: output off |
| cfg_in_slot_i | input | 6 | Input timeslot number |
| cfg_out_slot_i | input | 6 | Output timeslot number |
| rx_word_o | output | 8 | Last captured word, right-justified |
| rx_valid_o | output | 1 | One-cycle pulse when a word is captured |
| tx_word_i | input | 8 | Coded word from the processing stub |

## Verification
The assertions assume three things about the inputs.
- The bit clock stays high and low for several system-clock cycles each, so every synchronized edge is seen once and the counter settles before the output is recomputed.
- Frame sync rises together with the bit clock and falls before the next rising edge.
- Serial input holds steady from one rising edge to the next.

The bench drives all backplane inputs on the falling system-clock edge. It uses 16-cycle bits with 8-cycle phases and reads the output late in each bit, so every stimulus stays within these limits. Configuration changes are made between frames, except for the idle and busy flags, whose effect is meant to be immediate.

// File: rtl/tdm_slot_pkg.sv
package tdm_slot_pkg;

    typedef enum logic {
        FR_HUNT = 1'b0,
        FR_RUN  = 1'b1
    } frame_state_e;

    typedef enum logic {
        RX_WAIT  = 1'b0,
        RX_SHIFT = 1'b1
    } rx_state_e;

    typedef enum logic {
        TX_HIZ   = 1'b0,
        TX_DRIVE = 1'b1
    } tx_state_e;

    typedef struct packed {
        logic in_nib;
        logic out_nib;
    } width_sel_t;

    // Slot widths follow the coding direction; bypass keeps both sides equal.
    function automatic width_sel_t pick_widths(input logic compress, input logic bypass);
        width_sel_t w;
        w.in_nib  = !compress;
        w.out_nib = bypass ? !compress : compress;
        return w;
    endfunction

endpackage

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer
    import tdm_slot_pkg::*;
#(
    parameter int SYNC_STAGES    = 2,
    parameter int FRAME_BITS_MAX = 512,
    parameter int CNT_W          = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bclk_i,
    input  logic             fsync_i,
    input  logic             sdin_i,
    output logic [CNT_W-1:0] bit_cnt_o,
    output logic             bit_new_o,
    output logic             frame_pre_o,
    output logic             sample_o,
    output logic             sdin_s_o,
    output logic             running_o
);

    localparam logic [CNT_W-1:0] CNT_STOP = CNT_W'(FRAME_BITS_MAX);

    // Each stage carries {bit clock, frame sync, serial data}.
    logic [2:0]       stage_q [SYNC_STAGES];
    logic             bclk_prev_q;
    logic             rise;
    logic             fall;
    logic             fs_s;
    frame_state_e     state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             bit_new_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < SYNC_STAGES; k++) begin
                stage_q[k] <= 3'b000;
            end
            bclk_prev_q <= 1'b0;
        end else begin
            stage_q[0] <= {bclk_i, fsync_i, sdin_i};
            for (int k = 1; k < SYNC_STAGES; k++) begin
                stage_q[k] <= stage_q[k-1];
            end
            bclk_prev_q <= stage_q[SYNC_STAGES-1][2];
        end
    end

    assign rise = stage_q[SYNC_STAGES-1][2] & ~bclk_prev_q;
    assign fall = ~stage_q[SYNC_STAGES-1][2] & bclk_prev_q;
    assign fs_s = stage_q[SYNC_STAGES-1][1];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FR_HUNT;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FR_HUNT: if (rise && fs_s) state_d = FR_RUN;
            FR_RUN:  state_d = FR_RUN;
        endcase
    end

    // Bit index: zero on a sync edge, otherwise step up to the stop value.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            bit_new_q <= 1'b0;
        end else begin
            bit_new_q <= rise && (fs_s || state_q == FR_RUN);
            if (rise && fs_s) begin
                cnt_q <= '0;
            end else if (rise && state_q == FR_RUN && cnt_q != CNT_STOP) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign bit_cnt_o   = cnt_q;
    assign bit_new_o   = bit_new_q;
    assign frame_pre_o = rise && fs_s;
    assign sample_o    = fall && (state_q == FR_RUN);
    assign sdin_s_o    = stage_q[SYNC_STAGES-1][0];
    assign running_o   = (state_q == FR_RUN);

    AST_FRAME_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pre_o |=> (bit_cnt_o == '0) && bit_new_o); // R1
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt_o <= CNT_STOP); // R1
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && !fs_s && running_o && bit_cnt_o != CNT_STOP)
        |=> bit_cnt_o == CNT_W'($past(bit_cnt_o) + 1'b1)); // R1

endmodule

// File: rtl/tdm_slot_rx.sv
module tdm_slot_rx
    import tdm_slot_pkg::*;
#(
    parameter int CNT_W  = 10,
    parameter int SLOT_W = 6,
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  bit_cnt_i,
    input  logic              sample_i,
    input  logic              frame_pre_i,
    input  logic              sdin_i,
    input  logic              in_nib_i,
    input  logic [SLOT_W-1:0] in_slot_i,
    input  logic              idle_i,
    output logic [WORD_W-1:0] rx_word_o,
    output logic              rx_valid_o
);

    localparam int NIB_W   = WORD_W / 2;
    localparam int BYTE_LG = $clog2(WORD_W);
    localparam int NIB_LG  = $clog2(NIB_W);

    rx_state_e          state_q, state_d;
    logic [CNT_W-1:0]   slot_idx;
    logic [BYTE_LG-1:0] pos;
    logic [BYTE_LG-1:0] last;
    logic               hit;
    logic               take;
    logic [WORD_W-2:0]  shreg_q;
    logic [WORD_W-1:0]  word_full;
    logic [WORD_W-1:0]  word_q;
    logic               valid_q;

    assign slot_idx = in_nib_i ? (bit_cnt_i >> NIB_LG) : (bit_cnt_i >> BYTE_LG);
    assign hit      = (slot_idx == CNT_W'(in_slot_i));
    assign pos      = in_nib_i ? BYTE_LG'(bit_cnt_i[NIB_LG-1:0]) : bit_cnt_i[BYTE_LG-1:0];
    assign last     = in_nib_i ? BYTE_LG'(NIB_W - 1) : BYTE_LG'(WORD_W - 1);
    assign take     = sample_i && hit && !idle_i;

    assign word_full = in_nib_i ? WORD_W'({shreg_q[NIB_W-2:0], sdin_i})
                                : {shreg_q, sdin_i};

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_WAIT;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_WAIT: begin
                if (take && pos == '0) state_d = RX_SHIFT;
            end
            RX_SHIFT: begin
                if (frame_pre_i)                   state_d = RX_WAIT;
                else if (take && pos == last)      state_d = RX_WAIT;
                else if (sample_i && !take)        state_d = RX_WAIT;
            end
        endcase
    end

    // Outputs and shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            word_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (take && (state_q == RX_SHIFT || pos == '0)) begin
                shreg_q <= {shreg_q[WORD_W-3:0], sdin_i};
            end
            if (take && state_q == RX_SHIFT && pos == last && !frame_pre_i) begin
                word_q  <= word_full;
                valid_q <= 1'b1;
            end
        end
    end

    assign rx_word_o  = word_q;
    assign rx_valid_o = valid_q;

    AST_RX_NIB_JUSTIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_o && $past(in_nib_i)) |-> rx_word_o[WORD_W-1:NIB_W] == '0); // R6
    AST_RX_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> $past(sample_i)); // R2

endmodule

// File: rtl/tdm_slot_tx.sv
module tdm_slot_tx
    import tdm_slot_pkg::*;
#(
    parameter int CNT_W  = 10,
    parameter int SLOT_W = 6,
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  bit_cnt_i,
    input  logic              bit_new_i,
    input  logic              frame_pre_i,
    input  logic              running_i,
    input  logic              out_nib_i,
    input  logic [SLOT_W-1:0] out_slot_i,
    input  logic              idle_i,
    input  logic              busy_i,
    input  logic              bypass_i,
    input  logic [WORD_W-1:0] rx_word_i,
    input  logic [WORD_W-1:0] tx_word_i,
    output logic              sd_o,
    output logic              oe_o
);

    localparam int NIB_W   = WORD_W / 2;
    localparam int BYTE_LG = $clog2(WORD_W);
    localparam int NIB_LG  = $clog2(NIB_W);

    tx_state_e          state_q, state_d;
    logic [WORD_W-1:0]  hold_q;
    logic [CNT_W-1:0]   slot_idx;
    logic [BYTE_LG-1:0] pos;
    logic [BYTE_LG-1:0] bit_sel;
    logic               hit;
    logic               permit;
    logic               sd_q;
    logic               oe_q;

    assign slot_idx = out_nib_i ? (bit_cnt_i >> NIB_LG) : (bit_cnt_i >> BYTE_LG);
    assign hit      = (slot_idx == CNT_W'(out_slot_i));
    assign pos      = out_nib_i ? BYTE_LG'(bit_cnt_i[NIB_LG-1:0]) : bit_cnt_i[BYTE_LG-1:0];
    assign bit_sel  = out_nib_i ? BYTE_LG'(NIB_W - 1) - pos : BYTE_LG'(WORD_W - 1) - pos;
    assign permit   = running_i && !idle_i && !busy_i;

    // Word for the coming frame is latched at the sync edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           hold_q <= '0;
        else if (frame_pre_i) hold_q <= bypass_i ? rx_word_i : tx_word_i;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_HIZ;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_HIZ: begin
                if (permit && bit_new_i && hit) state_d = TX_DRIVE;
            end
            TX_DRIVE: begin
                if (!permit)                 state_d = TX_HIZ;
                else if (bit_new_i && !hit)  state_d = TX_HIZ;
            end
        endcase
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sd_q <= 1'b0;
            oe_q <= 1'b0;
        end else begin
            oe_q <= (state_d == TX_DRIVE);
            if (bit_new_i) sd_q <= hold_q[bit_sel];
        end
    end

    assign sd_o = sd_q;
    assign oe_o = oe_q;

    AST_TX_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
        oe_o |-> $past(running_i)); // R11
    AST_TX_ENTER_AT_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_o) |-> $past(bit_new_i)); // R12

endmodule

// File: rtl/tdm_slot_port.sv
module tdm_slot_port
    import tdm_slot_pkg::*;
#(
    parameter int SYNC_STAGES    = 2,
    parameter int FRAME_BITS_MAX = 512,
    parameter int SLOT_W         = 6,
    parameter int WORD_W         = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_i,
    input  logic              fsync_i,
    input  logic              sdin_i,
    output logic              sdout_o,
    output logic              sdout_oe_o,
    input  logic              cfg_compress_i,
    input  logic              cfg_bypass_i,
    input  logic              cfg_idle_i,
    input  logic              cfg_busy_i,
    input  logic [SLOT_W-1:0] cfg_in_slot_i,
    input  logic [SLOT_W-1:0] cfg_out_slot_i,
    output logic [WORD_W-1:0] rx_word_o,
    output logic              rx_valid_o,
    input  logic [WORD_W-1:0] tx_word_i
);

    localparam int CNT_W = $clog2(FRAME_BITS_MAX) + 1;

    logic [CNT_W-1:0] bit_cnt;
    logic             bit_new;
    logic             frame_pre;
    logic             sample;
    logic             sdin_s;
    logic             running;
    width_sel_t       widths;
    logic             sd;
    logic             oe;

    assign widths = pick_widths(cfg_compress_i, cfg_bypass_i);

    tdm_frame_timer #(
        .SYNC_STAGES   (SYNC_STAGES),
        .FRAME_BITS_MAX(FRAME_BITS_MAX),
        .CNT_W         (CNT_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .bclk_i     (bclk_i),
        .fsync_i    (fsync_i),
        .sdin_i     (sdin_i),
        .bit_cnt_o  (bit_cnt),
        .bit_new_o  (bit_new),
        .frame_pre_o(frame_pre),
        .sample_o   (sample),
        .sdin_s_o   (sdin_s),
        .running_o  (running)
    );

    tdm_slot_rx #(
        .CNT_W (CNT_W),
        .SLOT_W(SLOT_W),
        .WORD_W(WORD_W)
    ) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_cnt_i  (bit_cnt),
        .sample_i   (sample),
        .frame_pre_i(frame_pre),
        .sdin_i     (sdin_s),
        .in_nib_i   (widths.in_nib),
        .in_slot_i  (cfg_in_slot_i),
        .idle_i     (cfg_idle_i),
        .rx_word_o  (rx_word_o),
        .rx_valid_o (rx_valid_o)
    );

    tdm_slot_tx #(
        .CNT_W (CNT_W),
        .SLOT_W(SLOT_W),
        .WORD_W(WORD_W)
    ) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_cnt_i  (bit_cnt),
        .bit_new_i  (bit_new),
        .frame_pre_i(frame_pre),
        .running_i  (running),
        .out_nib_i  (widths.out_nib),
        .out_slot_i (cfg_out_slot_i),
        .idle_i     (cfg_idle_i),
        .busy_i     (cfg_busy_i),
        .bypass_i   (cfg_bypass_i),
        .rx_word_i  (rx_word_o),
        .tx_word_i  (tx_word_i),
        .sd_o       (sd),
        .oe_o       (oe)
    );

    assign sdout_oe_o = oe;
    assign sdout_o    = oe ? sd : 1'bz;

    AST_NO_DRIVE_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !sdout_oe_o); // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_idle_i) |-> (!sdout_oe_o && !rx_valid_o)); // R9
    AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_busy_i) |-> !sdout_oe_o); // R10
    AST_RX_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o); // R6
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sdout_oe_o && $past(sdout_oe_o) && !$past(bit_new)) |-> $stable(sdout_o)); // R2

endmodule

// File: tb/sim_tdm_slot_port.sv
module sim_tdm_slot_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bclk_i = 1'b0;
    logic       fsync_i = 1'b0;
    logic       sdin_i = 1'b0;
    logic       sdout_o;
    logic       sdout_oe_o;
    logic       cfg_compress_i = 1'b1;
    logic       cfg_bypass_i = 1'b0;
    logic       cfg_idle_i = 1'b0;
    logic       cfg_busy_i = 1'b0;
    logic [5:0] cfg_in_slot_i = '0;
    logic [5:0] cfg_out_slot_i = '0;
    logic [7:0] rx_word_o;
    logic       rx_valid_o;
    logic [7:0] tx_word_i = '0;

    always #10 clk = ~clk;

    tdm_slot_port u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .bclk_i        (bclk_i),
        .fsync_i       (fsync_i),
        .sdin_i        (sdin_i),
        .sdout_o       (sdout_o),
        .sdout_oe_o    (sdout_oe_o),
        .cfg_compress_i(cfg_compress_i),
        .cfg_bypass_i  (cfg_bypass_i),
        .cfg_idle_i    (cfg_idle_i),
        .cfg_busy_i    (cfg_busy_i),
        .cfg_in_slot_i (cfg_in_slot_i),
        .cfg_out_slot_i(cfg_out_slot_i),
        .rx_word_o     (rx_word_o),
        .rx_valid_o    (rx_valid_o),
        .tx_word_i     (tx_word_i)
    );

    int   n_run  = 0;
    int   n_fail = 0;
    bit   done   = 0;
    int   rx_pulses = 0;
    logic [7:0] rx_seen = '0;

    logic fb_in  [640];
    logic fb_oe  [640];
    logic fb_dat [640];
    logic ex_oe  [640];

    // Vector fields: compress, bypass, in slot, out slot, input word, stub word
    localparam logic [29:0] VEC [8] = '{
        {1'b1, 1'b0, 6'd0,  6'd0,  8'hA5, 8'h09},
        {1'b1, 1'b0, 6'd23, 6'd47, 8'h3C, 8'h06},
        {1'b0, 1'b0, 6'd5,  6'd2,  8'h0B, 8'hC3},
        {1'b0, 1'b0, 6'd47, 6'd23, 8'h07, 8'h81},
        {1'b1, 1'b1, 6'd3,  6'd10, 8'h96, 8'hFF},
        {1'b0, 1'b1, 6'd40, 6'd1,  8'h0D, 8'h00},
        {1'b1, 1'b0, 6'd60, 6'd60, 8'h55, 8'h0A},
        {1'b0, 1'b1, 6'd12, 6'd12, 8'h0E, 8'h03}
    };

    always @(negedge clk) begin
        if (rst_n && rx_valid_o) begin
            rx_pulses++;
            rx_seen = rx_word_o;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_frame(input int nbits, input bit sync);
        for (int i = 0; i < nbits; i++) begin
            bclk_i  = 1'b1;
            fsync_i = sync && (i == 0);
            sdin_i  = fb_in[i];
            repeat (8) @(negedge clk);
            bclk_i = 1'b0;
            repeat (7) @(negedge clk);
            fb_oe[i]  = sdout_oe_o;
            fb_dat[i] = sdout_o;
            @(negedge clk);
        end
        fsync_i = 1'b0;
    endtask

    task automatic fill_in(input int nbits, input bit nib, input int slot, input logic [7:0] w);
        int wid;
        wid = nib ? 4 : 8;
        for (int i = 0; i < nbits; i++) fb_in[i] = (i % 3 == 0);
        for (int b = 0; b < wid; b++) begin
            if (slot * wid + b < nbits) fb_in[slot * wid + b] = w[wid - 1 - b];
        end
    endtask

    task automatic expect_out(input int nbits, input bit nib, input int slot);
        int wid;
        wid = nib ? 4 : 8;
        for (int i = 0; i < nbits; i++) ex_oe[i] = 1'b0;
        for (int b = 0; b < wid; b++) begin
            if (slot * wid + b < nbits) ex_oe[slot * wid + b] = 1'b1;
        end
    endtask

    task automatic compare_out(input string req, input int nbits, input bit nib,
                               input int slot, input logic [7:0] w);
        int bad;
        int got;
        int wid;
        int wexp;
        bad = 0;
        got = 0;
        wid = nib ? 4 : 8;
        wexp = nib ? int'(w[3:0]) : int'(w);
        for (int i = 0; i < nbits; i++) begin
            if (fb_oe[i] !== ex_oe[i]) bad++;
        end
        check(bad == 0, req, "drive-enable mismatching bits", bad, 0);
        if (slot * wid + wid <= nbits) begin
            for (int b = 0; b < wid; b++) begin
                got = (got << 1) | ((fb_dat[slot * wid + b] === 1'b1) ? 1 : 0);
            end
            check(got == wexp, req, "output slot word", got, wexp);
        end
    endtask

    function automatic int count_oe(input int nbits);
        int n;
        n = 0;
        for (int i = 0; i < nbits; i++) if (fb_oe[i] !== 1'b0) n++;
        return n;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic       c, b;
        logic [5:0] is, os;
        logic [7:0] iw, tw;
        int         p0;
        bit         in_nib, out_nib;
        int         in_w;

        // Reset state, R11 and R12
        repeat (6) @(negedge clk);
        check(sdout_oe_o == 1'b0, "R11", "oe in reset", sdout_oe_o, 0);
        check(rx_valid_o == 1'b0, "R11", "rx_valid in reset", rx_valid_o, 0);
        check(sdout_o === 1'bz, "R12", "sdout high-Z in reset", (sdout_o === 1'bz) ? 1 : 0, 1);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R11: no frame sync yet, nothing driven
        cfg_compress_i = 1'b1; cfg_in_slot_i = 6'd0; cfg_out_slot_i = 6'd0;
        tx_word_i = 8'h0F;
        fill_in(40, 1'b0, 0, 8'hFF);
        run_frame(40, 1'b0);
        check(count_oe(40) == 0, "R11", "driven bits before first sync", count_oe(40), 0);

        // Table-driven vectors: R3 R4 R5 R6 R7 R8 R12
        for (int v = 0; v < 8; v++) begin
            {c, b, is, os, iw, tw} = VEC[v];
            cfg_compress_i = c;
            cfg_bypass_i   = b;
            cfg_in_slot_i  = is;
            cfg_out_slot_i = os;
            tx_word_i      = tw;
            in_nib  = !c;
            out_nib = b ? !c : c;
            in_w    = in_nib ? 4 : 8;
            fill_in(193, in_nib, is, iw);
            p0 = rx_pulses;
            run_frame(193, 1'b1);
            if (int'(is) * in_w + in_w <= 193) begin
                check(rx_pulses - p0 == 1, "R6", "capture pulses per frame", rx_pulses - p0, 1);
                check(rx_seen == (in_nib ? {4'h0, iw[3:0]} : iw), "R4 R6", "captured word",
                      rx_seen, in_nib ? {4'h0, iw[3:0]} : iw);
            end else begin
                check(rx_pulses == p0, "R3", "capture of slot past frame end", rx_pulses - p0, 0);
            end
            expect_out(193, out_nib, os);
            run_frame(193, 1'b1);
            compare_out(b ? "R8 R5 R12" : "R7 R4 R5 R12", 193, out_nib, os, b ? iw : tw);
        end
        cfg_bypass_i = 1'b0;

        // R9: idle keeps output off and stops capture
        cfg_compress_i = 1'b1; cfg_in_slot_i = 6'd0; cfg_out_slot_i = 6'd0;
        tx_word_i = 8'h0A;
        cfg_idle_i = 1'b1;
        fill_in(193, 1'b0, 0, 8'h5A);
        p0 = rx_pulses;
        run_frame(193, 1'b1);
        check(count_oe(193) == 0, "R9", "driven bits while idle (frame 1)", count_oe(193), 0);
        run_frame(193, 1'b1);
        check(count_oe(193) == 0, "R9", "driven bits while idle (frame 2)", count_oe(193), 0);
        check(rx_pulses == p0, "R9", "captures while idle", rx_pulses - p0, 0);
        cfg_idle_i = 1'b0;

        // R10: busy keeps output off, driving resumes afterwards
        cfg_in_slot_i = 6'd1; cfg_out_slot_i = 6'd2; tx_word_i = 8'h05;
        fill_in(193, 1'b0, 1, 8'h33);
        run_frame(193, 1'b1);
        cfg_busy_i = 1'b1;
        run_frame(193, 1'b1);
        check(count_oe(193) == 0, "R10", "driven bits while busy", count_oe(193), 0);
        cfg_busy_i = 1'b0;
        expect_out(193, 1'b1, 2);
        run_frame(193, 1'b1);
        compare_out("R10", 193, 1'b1, 2, 8'h05);

        // R1 R3: long frame, top byte slot, index stops past the last slot
        cfg_compress_i = 1'b0; cfg_in_slot_i = 6'd0; cfg_out_slot_i = 6'd63;
        tx_word_i = 8'hA7;
        fill_in(600, 1'b1, 0, 8'h03);
        expect_out(600, 1'b0, 63);
        run_frame(600, 1'b1);
        compare_out("R1 R3", 600, 1'b0, 63, 8'hA7);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule